// File: doc/BRIEF.md
# Supply Reset Pulse Generator

This block turns three reset causes into one clean system reset. The causes are the block's own power-on, a synchronous undervoltage flag from an external comparator, and an active-low manual reset pin. Reset is held while any cause is present. After the last cause goes away, reset stays asserted for a fixed stretch of tick-clock cycles. The reset appears on two complementary outputs, one active-low and one active-high.

The manual pin may come from a push-button or from another block's output, such as a watchdog expiry line looped back to it. It is synchronised through two flops and then qualified: it must hold a new level for a set number of consecutive samples before the block accepts it. A status output reports which cause last held reset.

A state machine with three states sets the timing:

- **ST_HOLD**: at least one cause is active.
- **ST_STRETCH**: no cause is active, and the stretch counter is running.
- **ST_RUN**: reset is released.

The transitions are:

- **T_CLEAR** (ST_HOLD to ST_STRETCH): no cause remains.
- **T_REARM** (ST_STRETCH to ST_HOLD) and **T_TRIP** (ST_RUN to ST_HOLD): a cause appears.
- **T_EXPIRE** (ST_STRETCH to ST_RUN): the counter reaches its last count.

Power-on reset places the machine in ST_STRETCH with the counter at zero.

Top module: `sysrst_gen`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is 0 and `last_cause` is 2'b00. After `por_n` rises, with no other cause present, reset stays asserted for STRETCH_CYCLES rising edges. It is released on edge number STRETCH_CYCLES.
- R2: When `uv_flag` is sampled high on a rising edge, reset is asserted after that same edge.
- R3: `man_rst_n` passes through a two-flop synchroniser. It then takes effect only after DEBOUNCE_SAMPLES consecutive samples at the new level. A low pulse shorter than DEBOUNCE_SAMPLES clock cycles leaves `sys_rst_n` at 1.
- R4: After the last edge on which a cause was seen, reset is released on rising edge number STRETCH_CYCLES+1.
- R5: If a cause appears during the stretch, the whole STRETCH_CYCLES count starts again once that cause clears.
- R6: `sys_rst` is always the logical complement of `sys_rst_n`.
- R7: `last_cause` holds the most recent cause: 2'b00 for power-up, 2'b01 for undervoltage and 2'b10 for manual. It updates on every edge where a cause is active. When undervoltage and manual are both active, undervoltage wins. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running tick clock |
| por_n | input | 1 | Block's own power-on reset, asynchronous, active low |
| uv_flag | input | 1 | Undervoltage flag, synchronous to clk, active high |
| man_rst_n | input | 1 | Manual reset request, asynchronous, active low |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |
| last_cause | output | 2 | Cause that last held reset (R7 encoding) |

## Verification
The assertions assume that `uv_flag` is already synchronous to `clk` and changes only between edges. They also assume that `por_n` is low at start-up, so that every register begins from its reset value. The bench drives all inputs on falling edges and holds `por_n` low across several edges before releasing it. It sends the manual pin through the synchroniser like any other asynchronous level, so the debounce latency it relies on is counted in whole cycles.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    typedef enum logic [1:0] {
        CAUSE_POWERUP = 2'b00,
        CAUSE_UNDERV  = 2'b01,
        CAUSE_MANUAL  = 2'b10
    } cause_e;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'b00,
        ST_STRETCH = 2'b01,
        ST_RUN     = 2'b10
    } rst_state_e;

endpackage

// File: rtl/sysrst_debounce.sv
module sysrst_debounce #(
    parameter int SYNC_STAGES      = 2,
    parameter int DEBOUNCE_SAMPLES = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic level_n
);
    localparam int CW = (DEBOUNCE_SAMPLES > 1) ? $clog2(DEBOUNCE_SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_SAMPLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   stable_q;
    logic                   sampled;

    // Synchroniser chain; the reset value is the inactive (high) level.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
        end
    end

    assign sampled = sync_q[SYNC_STAGES-1];

    // The accepted level changes only after LAST+1 consecutive differing samples.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q    <= '0;
            stable_q <= 1'b1;
        end else if (sampled != stable_q) begin
            if (cnt_q == LAST) begin
                stable_q <= sampled;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign level_n = stable_q;
endmodule

// File: rtl/sysrst_fsm.sv
module sysrst_fsm
    import sysrst_pkg::*;
#(
    parameter int STRETCH_CYCLES = 200000
) (
    input  logic clk,
    input  logic por_n,
    input  logic cause_any,
    output logic rst_active
);
    localparam int CW = (STRETCH_CYCLES > 1) ? $clog2(STRETCH_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRETCH_CYCLES - 1);

    rst_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          cnt_done;

    assign cnt_done = (cnt_q == LAST);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    if (!cause_any) state_d = ST_STRETCH;   // T_CLEAR
            ST_STRETCH: if (cause_any)  state_d = ST_HOLD;      // T_REARM
                        else if (cnt_done) state_d = ST_RUN;     // T_EXPIRE
            ST_RUN:     if (cause_any)  state_d = ST_HOLD;      // T_TRIP
            default:    state_d = ST_HOLD;
        endcase
    end

    // State register; power-on starts the stretch from zero.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_STRETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // The stretch counter runs only in ST_STRETCH.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_STRETCH && !cause_any && !cnt_done) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // Output decode.
    always_comb begin
        rst_active = (state_q != ST_RUN);
    end
endmodule

// File: rtl/sysrst_cause.sv
module sysrst_cause
    import sysrst_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  logic   uv_flag,
    input  logic   man_level_n,
    output cause_e cause
);
    cause_e cause_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= CAUSE_POWERUP;
        end else if (uv_flag) begin
            cause_q <= CAUSE_UNDERV;
        end else if (!man_level_n) begin
            cause_q <= CAUSE_MANUAL;
        end
    end

    assign cause = cause_q;
endmodule

// File: rtl/sysrst_gen.sv
module sysrst_gen
    import sysrst_pkg::*;
#(
    parameter int STRETCH_CYCLES   = 200000,
    parameter int DEBOUNCE_SAMPLES = 8,
    parameter int SYNC_STAGES      = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       uv_flag,
    input  logic       man_rst_n,
    output logic       sys_rst_n,
    output logic       sys_rst,
    output logic [1:0] last_cause
);
    logic   man_level_n;
    logic   cause_any;
    logic   rst_active;
    cause_e cause;

    sysrst_debounce #(
        .SYNC_STAGES     (SYNC_STAGES),
        .DEBOUNCE_SAMPLES(DEBOUNCE_SAMPLES)
    ) u_deb (
        .clk    (clk),
        .por_n  (por_n),
        .pin_n  (man_rst_n),
        .level_n(man_level_n)
    );

    assign cause_any = uv_flag | ~man_level_n;

    sysrst_fsm #(
        .STRETCH_CYCLES(STRETCH_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .cause_any (cause_any),
        .rst_active(rst_active)
    );

    sysrst_cause u_cause (
        .clk        (clk),
        .por_n      (por_n),
        .uv_flag    (uv_flag),
        .man_level_n(man_level_n),
        .cause      (cause)
    );

    assign sys_rst_n  = ~rst_active;
    assign sys_rst    = rst_active;
    assign last_cause = cause;
endmodule

// File: rtl/sysrst_gen_chk.sv
module sysrst_gen_chk #(
    parameter int STRETCH_CYCLES = 200000
) (
    input logic       clk,
    input logic       por_n,
    input logic       uv_flag,
    input logic       sys_rst_n,
    input logic       sys_rst,
    input logic [1:0] last_cause
);
    localparam int QW = $clog2(STRETCH_CYCLES + 2);
    localparam logic [QW-1:0] QMAX = QW'(STRETCH_CYCLES);

    // Saturating count of edges since undervoltage was last seen.
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                quiet_q <= '0;
        else if (uv_flag)          quiet_q <= '0;
        else if (quiet_q != QMAX)  quiet_q <= quiet_q + 1'b1;
    end

    // R2
    a_r2_uv_asserts: assert property (@(posedge clk) disable iff (!por_n)
        uv_flag |=> !sys_rst_n);

    // R6
    a_r6_complement: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst == !sys_rst_n);

    // R4
    a_r4_full_stretch: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> (quiet_q >= QMAX));

    // R7
    a_r7_uv_cause: assert property (@(posedge clk) disable iff (!por_n)
        uv_flag |=> (last_cause == 2'b01));

    // R7
    a_r7_legal_cause: assert property (@(posedge clk) disable iff (!por_n)
        last_cause != 2'b11);
endmodule

bind sysrst_gen sysrst_gen_chk #(
    .STRETCH_CYCLES(STRETCH_CYCLES)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .uv_flag   (uv_flag),
    .sys_rst_n (sys_rst_n),
    .sys_rst   (sys_rst),
    .last_cause(last_cause)
);

// File: tb/sysrst_gen_tb.sv
module sysrst_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STRETCH    = 20;
    localparam int DEB        = 4;
    localparam int NVEC       = 18;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       uv_flag = 1'b0;
    logic       man_rst_n = 1'b1;
    logic       sys_rst_n;
    logic       sys_rst;
    logic [1:0] last_cause;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysrst_gen #(
        .STRETCH_CYCLES  (STRETCH),
        .DEBOUNCE_SAMPLES(DEB),
        .SYNC_STAGES     (2)
    ) u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .uv_flag   (uv_flag),
        .man_rst_n (man_rst_n),
        .sys_rst_n (sys_rst_n),
        .sys_rst   (sys_rst),
        .last_cause(last_cause)
    );

    // Vector fields: {uv, man_n, edges[7:0], exp_rst_n, exp_cause[1:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'd5,  1'b1, 2'b00},  // R6 idle run
        {1'b1, 1'b1, 8'd1,  1'b0, 2'b01},  // R2
        {1'b0, 1'b1, 8'd19, 1'b0, 2'b01},  // R4 still stretching
        {1'b0, 1'b1, 8'd2,  1'b1, 2'b01},  // R4 release at edge 21
        {1'b0, 1'b0, 8'd3,  1'b1, 2'b01},  // R3 not yet qualified
        {1'b0, 1'b0, 8'd4,  1'b0, 2'b10},  // R3 qualified, R7
        {1'b0, 1'b1, 8'd20, 1'b0, 2'b10},  // R4 manual release stretching
        {1'b0, 1'b1, 8'd8,  1'b1, 2'b10},  // R4
        {1'b1, 1'b1, 8'd2,  1'b0, 2'b01},  // R2
        {1'b1, 1'b0, 8'd8,  1'b0, 2'b01},  // R7 priority
        {1'b0, 1'b0, 8'd25, 1'b0, 2'b10},  // R7 manual alone
        {1'b0, 1'b1, 8'd26, 1'b0, 2'b10},  // R4
        {1'b0, 1'b1, 8'd1,  1'b1, 2'b10},  // R4
        {1'b1, 1'b1, 8'd1,  1'b0, 2'b01},  // R2
        {1'b0, 1'b1, 8'd10, 1'b0, 2'b01},  // R5 mid stretch
        {1'b1, 1'b1, 8'd1,  1'b0, 2'b01},  // R5 new cause
        {1'b0, 1'b1, 8'd20, 1'b0, 2'b01},  // R5 full restart
        {1'b0, 1'b1, 8'd1,  1'b1, 2'b01}   // R5 release
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {rst_n,cause} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
        if (sys_rst !== ~sys_rst_n) begin
            n_fail++;
            $display("FAIL R6: sys_rst actual=%b expected=%b", sys_rst, ~sys_rst_n);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic por_sequence(input string req);
        @(negedge clk);
        por_n = 1'b0;
        #1;
        check(req, {sys_rst_n, last_cause}, {1'b0, 2'b00});
        edges(2);
        por_n = 1'b1;
        edges(STRETCH - 1);
        check(req, {sys_rst_n, last_cause}, {1'b0, 2'b00});
        edges(1);
        check(req, {sys_rst_n, last_cause}, {1'b1, 2'b00});
    endtask

    initial begin
        // R1: power-up reset and stretch
        por_sequence("R1");

        for (int i = 0; i < NVEC; i++) begin
            uv_flag   = VEC[i][12];
            man_rst_n = VEC[i][11];
            edges(int'(VEC[i][10:3]));
            check($sformatf("vector %0d", i), {sys_rst_n, last_cause}, VEC[i][2:0]);
        end

        // R3: a short manual glitch never reaches the outputs
        man_rst_n = 1'b0;
        edges(DEB - 1);
        man_rst_n = 1'b1;
        for (int k = 0; k < 15; k++) begin
            edges(1);
            check("R3 glitch", {sys_rst_n, last_cause}, {1'b1, 2'b01});
        end

        // R1: power-on reset again from the run state
        por_sequence("R1 again");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule